// File: doc/BRIEF.md
# Priority-Aware Processing Element Clock and Power Governor

This block decides, for every processing element in a pool, how fast it should be clocked and whether its core and its local memory should be powered. The pool is split into groups of identical element types. Each element runs at its type's base rate when it has power. The rate goes up one step while the element works on a high-priority task. It goes up one more step when every element of its type is busy. The chosen step is then limited by a per-element ceiling that software sets. The output is a small level code that a separate clock generator turns into a real frequency.

Power is sequenced around data prefetch. A prefetch-start pulse powers the element's local memory at once. The core stays off until the prefetch has nearly finished: it comes on a type-specific number of startup cycles before the prefetch completes, so that it is ready exactly when its data is in place. An element that is neither busy nor holding allocated local data is shut down completely. Software can disable any element, and a disabled element is held fully off.

Top module: `pcg_governor`

## Requirements
- R1: After reset every element is enabled, its core and memory power are off, and its level code is 0.
- R2: Level codes are 0 = off, 1 = base rate, 2 = twice base, 3 = four times base. A powered core that is not busy runs at code 1.
- R3: A powered, busy element with its high-priority input set runs at code 2 while at least one element of its type is not busy.
- R4: When every element of a type is busy, each powered one goes one step higher: code 3 with high priority and code 2 without.
- R5: The level code never exceeds the element's ceiling. A ceiling of 0 is treated as 1.
- R6: A disable pulse turns off core and memory power and drives the level code to 0 on the next clock edge. If enable and disable arrive together, disable takes precedence.
- R7: A prefetch-start pulse has no effect on a disabled element or on an element whose core is already on. An enable pulse on its own does not apply power.
- R8: A prefetch start of length L turns memory power on at the next edge. When L is greater than the type's startup count S, the core turns on L−S edges after that start edge.
- R9: When L ≤ S, the core and the memory turn on together at the edge that samples the start.
- R10: A powered element whose busy input and data-held input are both low is switched fully off at the next edge. While either input is high, it stays on.
- R11: Core power is never on while memory power is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_busy | input | NUM_PE | Element is executing a task |
| pe_hiprio | input | NUM_PE | Current task of the element is high priority |
| pe_holds | input | NUM_PE | Element's local memory holds allocated data |
| en_set | input | NUM_PE | Enable pulse per element |
| en_clr | input | NUM_PE | Disable pulse per element |
| cap_level | input | NUM_PE*2 | Per-element ceiling level code |
| pf_start | input | NUM_PE | Prefetch start pulse per element |
| pf_len | input | CNT_W | Prefetch length in cycles, shared, sampled with pf_start |
| core_pwr | output | NUM_PE | Core power enable |
| mem_pwr | output | NUM_PE | Local memory power enable |
| level | output | NUM_PE*2 | Frequency level code per element |

## Verification
The checks assume that the scheduler raises busy only on an element whose core is powered, and that each prefetch start comes with a valid length on the shared bus in the same cycle. The bench keeps the data-held input high while it waits for a core to power up, so that the idle shutdown cannot cut a sequence short, and it changes inputs only one cycle after an edge. The ceiling check compares each level code with the ceiling that was present at the edge that produced it, so it does not depend on how the ceiling changes between edges.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_OFF  = 2'd0;
    localparam lvl_t LVL_BASE = 2'd1;
    localparam lvl_t LVL_DBL  = 2'd2;
    localparam lvl_t LVL_QUAD = 2'd3;

    typedef enum logic [1:0] {
        PWR_OFF = 2'd0,
        PWR_MEM = 2'd1,
        PWR_ON  = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic busy;
        logic hiprio;
        logic holds;
    } pe_load_t;

    // a ceiling of zero still permits the base rate
    function automatic lvl_t eff_cap(lvl_t c);
        return (c == LVL_OFF) ? LVL_BASE : c;
    endfunction

    function automatic lvl_t pick_level(pe_load_t ld, logic type_full, lvl_t cap);
        lvl_t raw;
        lvl_t lim;
        raw = LVL_BASE;
        if (ld.busy) begin
            if (ld.hiprio) raw = raw + LVL_BASE;
            if (type_full) raw = raw + LVL_BASE;
        end
        lim = eff_cap(cap);
        return (raw > lim) ? lim : raw;
    endfunction

endpackage

// File: rtl/pcg_type_monitor.sv
module pcg_type_monitor #(
    parameter int N_TYPES  = 2,
    parameter int PER_TYPE = 2,
    localparam int NUM_PE  = N_TYPES * PER_TYPE
) (
    input  logic [NUM_PE-1:0] busy,
    output logic [NUM_PE-1:0] peer_full
);

    logic [N_TYPES-1:0] type_full;

    for (genvar t = 0; t < N_TYPES; t++) begin : g_type
        assign type_full[t] = &busy[t*PER_TYPE +: PER_TYPE];
        for (genvar k = 0; k < PER_TYPE; k++) begin : g_member
            assign peer_full[t*PER_TYPE + k] = type_full[t];
        end
    end

endmodule

// File: rtl/pcg_pe_seq.sv
module pcg_pe_seq
    import pcg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] STARTUP = 8'd2
) (
    input  logic             clk,
    input  logic             rst,
    input  pe_load_t         load,
    input  logic             type_full,
    input  logic             en_set,
    input  logic             en_clr,
    input  lvl_t             cap,
    input  logic             pf_start,
    input  logic [CNT_W-1:0] pf_len,
    output logic             core_pwr,
    output logic             mem_pwr,
    output lvl_t             level
);

    pwr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             en_q, en_d;
    lvl_t             lvl_q, lvl_d;

    always_comb begin
        en_d = en_q;
        if (en_set) en_d = 1'b1;
        if (en_clr) en_d = 1'b0;
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en_d) begin
            st_d  = PWR_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PWR_OFF: begin
                    if (pf_start) begin
                        if (pf_len <= STARTUP) begin
                            st_d = PWR_ON;
                        end else begin
                            st_d  = PWR_MEM;
                            cnt_d = pf_len - STARTUP;
                        end
                    end
                end
                PWR_MEM: begin
                    if (cnt_q <= 1) begin
                        st_d  = PWR_ON;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                PWR_ON: begin
                    if (!load.busy && !load.holds) st_d = PWR_OFF;
                end
                default: st_d = PWR_OFF;
            endcase
        end
    end

    always_comb begin
        lvl_d = (st_d == PWR_ON) ? pick_level(load, type_full, cap) : LVL_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PWR_OFF;
            cnt_q <= '0;
            en_q  <= 1'b1;
            lvl_q <= LVL_OFF;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            en_q  <= en_d;
            lvl_q <= lvl_d;
        end
    end

    assign core_pwr = (st_q == PWR_ON);
    assign mem_pwr  = (st_q == PWR_ON) || (st_q == PWR_MEM);
    assign level    = lvl_q;

    AST_CORE_NEEDS_MEM: assert property (@(posedge clk) disable iff (rst)
        core_pwr |-> mem_pwr); // R11

    AST_OFF_LEVEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !core_pwr |-> (level == LVL_OFF)); // R2

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        en_clr |=> (!core_pwr && !mem_pwr && level == LVL_OFF)); // R6

    AST_LEVEL_CAPPED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (level <= eff_cap($past(cap)))); // R5

    AST_PF_IGNORED_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !en_set && pf_start) |=> !mem_pwr); // R7

endmodule

// File: rtl/pcg_governor.sv
module pcg_governor
    import pcg_pkg::*;
#(
    parameter int N_TYPES  = 2,
    parameter int PER_TYPE = 2,
    parameter int CNT_W    = 8,
    parameter logic [N_TYPES*CNT_W-1:0] STARTUP_CYC = {8'd4, 8'd2},
    localparam int NUM_PE  = N_TYPES * PER_TYPE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PE-1:0]       pe_busy,
    input  logic [NUM_PE-1:0]       pe_hiprio,
    input  logic [NUM_PE-1:0]       pe_holds,
    input  logic [NUM_PE-1:0]       en_set,
    input  logic [NUM_PE-1:0]       en_clr,
    input  logic [NUM_PE*LVL_W-1:0] cap_level,
    input  logic [NUM_PE-1:0]       pf_start,
    input  logic [CNT_W-1:0]        pf_len,
    output logic [NUM_PE-1:0]       core_pwr,
    output logic [NUM_PE-1:0]       mem_pwr,
    output logic [NUM_PE*LVL_W-1:0] level
);

    logic [NUM_PE-1:0] peer_full;

    pcg_type_monitor #(
        .N_TYPES  (N_TYPES),
        .PER_TYPE (PER_TYPE)
    ) u_mon (
        .busy      (pe_busy),
        .peer_full (peer_full)
    );

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        localparam int TY = i / PER_TYPE;
        pe_load_t ld;
        assign ld = '{busy: pe_busy[i], hiprio: pe_hiprio[i], holds: pe_holds[i]};

        pcg_pe_seq #(
            .CNT_W   (CNT_W),
            .STARTUP (STARTUP_CYC[TY*CNT_W +: CNT_W])
        ) u_seq (
            .clk       (clk),
            .rst       (rst),
            .load      (ld),
            .type_full (peer_full[i]),
            .en_set    (en_set[i]),
            .en_clr    (en_clr[i]),
            .cap       (cap_level[i*LVL_W +: LVL_W]),
            .pf_start  (pf_start[i]),
            .pf_len    (pf_len),
            .core_pwr  (core_pwr[i]),
            .mem_pwr   (mem_pwr[i]),
            .level     (level[i*LVL_W +: LVL_W])
        );
    end

endmodule

// File: tb/pcg_governor_test.sv
module pcg_governor_test;

    localparam int NPE = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NPE-1:0] pe_busy = '0, pe_hiprio = '0, pe_holds = '1;
    logic [NPE-1:0] en_set = '0, en_clr = '0, pf_start = '0;
    logic [2*NPE-1:0] cap_level = '1;
    logic [7:0]     pf_len = '0;
    logic [NPE-1:0] core_pwr, mem_pwr;
    logic [2*NPE-1:0] level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct packed {
        logic [7:0] pe;
        logic       core;
        logic       mem;
        logic [1:0] lvl;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    pcg_governor uut (
        .clk(clk), .rst(rst), .pe_busy(pe_busy), .pe_hiprio(pe_hiprio),
        .pe_holds(pe_holds), .en_set(en_set), .en_clr(en_clr),
        .cap_level(cap_level), .pf_start(pf_start), .pf_len(pf_len),
        .core_pwr(core_pwr), .mem_pwr(mem_pwr), .level(level)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_pe(int pe, logic c, logic m, logic [1:0] l, string tag);
        exp_t e;
        e.pe = 8'(pe); e.core = c; e.mem = m; e.lvl = l;
        sb_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t  e;
            string t;
            logic [1:0] got_l;
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            got_l = level[int'(e.pe)*2 +: 2];
            n_checks++;
            if (core_pwr[e.pe] !== e.core || mem_pwr[e.pe] !== e.mem || got_l !== e.lvl) begin
                n_fail++;
                $display("FAIL %s pe%0d: core/mem/level got %b/%b/%0d expected %b/%b/%0d",
                         t, e.pe, core_pwr[e.pe], mem_pwr[e.pe], got_l, e.core, e.mem, e.lvl);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        for (int p = 0; p < NPE; p++) expect_pe(p, 0, 0, 0, "R1 reset state");

        // R8: long prefetch on type-0 element (startup 2)
        pf_len = 8'd5; pf_start[0] = 1'b1;
        step(); pf_start[0] = 1'b0;
        expect_pe(0, 0, 1, 0, "R8 memory first");
        step(); step();
        expect_pe(0, 0, 1, 0, "R11 core still waits");
        step();
        expect_pe(0, 1, 1, 1, "R8 core at len-startup");
        expect_pe(0, 1, 1, 1, "R2 idle base level");

        // R9: short prefetch
        pf_len = 8'd1; pf_start[1] = 1'b1;
        step(); pf_start[1] = 1'b0;
        expect_pe(1, 1, 1, 1, "R9 together");

        pe_busy[0] = 1'b1; pe_hiprio[0] = 1'b1;
        step();
        expect_pe(0, 1, 1, 2, "R3 high priority");

        pe_busy[1] = 1'b1;
        step();
        expect_pe(0, 1, 1, 3, "R4 quad");
        expect_pe(1, 1, 1, 2, "R4 full no priority");

        cap_level[1:0] = 2'd2;
        step();
        expect_pe(0, 1, 1, 2, "R5 ceiling");
        cap_level[1:0] = 2'd0;
        step();
        expect_pe(0, 1, 1, 1, "R5 zero ceiling");
        cap_level[1:0] = 2'd3;

        // R6: disable wins over enable
        en_clr[1] = 1'b1; en_set[1] = 1'b1; pe_busy[1] = 1'b0;
        step(); en_clr[1] = 1'b0; en_set[1] = 1'b0;
        expect_pe(1, 0, 0, 0, "R6 disabled");
        expect_pe(0, 1, 1, 2, "R4 peer idle");

        pf_len = 8'd1; pf_start[1] = 1'b1;
        step(); pf_start[1] = 1'b0;
        expect_pe(1, 0, 0, 0, "R7 start while disabled");
        en_set[1] = 1'b1;
        step(); en_set[1] = 1'b0;
        expect_pe(1, 0, 0, 0, "R7 enable alone");
        pf_start[1] = 1'b1;
        step(); pf_start[1] = 1'b0;
        expect_pe(1, 1, 1, 1, "R9 after re-enable");

        pf_len = 8'd5; pf_start[0] = 1'b1;
        step(); pf_start[0] = 1'b0;
        expect_pe(0, 1, 1, 2, "R7 start while on");

        // R10: shutdown on idle and no held data
        pe_busy[0] = 1'b0; pe_hiprio[0] = 1'b0; pe_holds[0] = 1'b0;
        step();
        expect_pe(0, 0, 0, 0, "R10 idle off");
        pe_busy[1] = 1'b1; pe_holds[1] = 1'b0;
        step();
        expect_pe(1, 1, 1, 1, "R10 busy keeps on");
        pe_busy[1] = 1'b0;
        step();
        expect_pe(1, 0, 0, 0, "R10 released");

        // type 1 (startup 4)
        pf_len = 8'd10; pf_start[3] = 1'b1;
        step(); pf_start[3] = 1'b0;
        expect_pe(3, 0, 1, 0, "R8 type1 memory");
        repeat (5) step();
        expect_pe(3, 0, 1, 0, "R11 type1 waiting");
        step();
        expect_pe(3, 1, 1, 1, "R8 type1 core");

        pf_len = 8'd4; pf_start[2] = 1'b1;
        step(); pf_start[2] = 1'b0;
        expect_pe(2, 1, 1, 1, "R9 equal length");

        pe_busy[2] = 1'b1; pe_busy[3] = 1'b1; pe_hiprio[3] = 1'b1;
        step();
        expect_pe(3, 1, 1, 3, "R4 type1 quad");
        expect_pe(2, 1, 1, 2, "R4 type1 full");

        step(); step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule